// File: doc/BRIEF.md
# Shadow Stack Far-Return Verifier

This block checks a far return against a hardware shadow stack before the new shadow stack pointer is committed. A start pulse samples the current shadow stack pointer and the return target. The target is given as the returning CS selector, the return instruction pointer, the code segment base and the mode flags. The block then reads a three-entry record from the shadow stack through a simple request/valid read port. It compares that record with the architectural return target and reports either the restored pointer or a fault.

When the return drops to user privilege (level 3) from a more privileged level, no record is read. After the incoming pointer passes its alignment check, the result is simply the user-level pointer supplied on an input. Every operation ends with a one-cycle done pulse carrying a fault class and a 16-bit error code. The pointer output changes only on a fault-free completion.

Top module: `ssret_verifier`

## Requirements
- R1: When start is seen with any of the low 3 bits of cur_ssp set, the block completes with fault_kind = 1 (control protection) and fault_code = 3, and issues no read request.
- R2: Otherwise, on a non-user return, three reads are issued at cur_ssp, cur_ssp+8 and cur_ssp+16, one after the other. Each request and its address are held until rd_valid. The entries are taken in this order: previous pointer, linear return address, CS selector.
- R3: The expected linear return address is ret_ip when long_mode and cs_l are both 1. Otherwise it is the low 32 bits of ret_ip plus cs_base, truncated to 32 bits and zero-extended.
- R4: If the third entry differs from ret_cs zero-extended to 64 bits, the result is fault_kind = 1 with fault_code = 3.
- R5: If the second entry differs from the expected linear address, the result is fault_kind = 1 with fault_code = 3.
- R6: If bits [1:0] of the first entry (restored pointer) are not zero, the result is fault_kind = 1 with fault_code = 3.
- R7: With mode64 = 0, a restored pointer with a nonzero upper 32 bits gives fault_kind = 2 (general protection) with fault_code = 0. Any control-protection condition takes precedence over this.
- R8: When no check fails, done is raised with fault_kind = 0, fault_code = 0, and new_ssp equal to the first entry.
- R9: With to_user = 1 and an aligned cur_ssp, no read is issued. The block completes with fault_kind = 0 and new_ssp = user_ssp.
- R10: On any fault, new_ssp keeps the value it had before the operation.
- R11: After reset, done = 0, rd_req = 0, fault_kind = 0, fault_code = 0 and new_ssp = 0.
- R12: done is high for exactly one cycle per operation. A start pulse while an operation is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a verification, sampled when idle |
| cur_ssp | input | 64 | Current shadow stack pointer |
| ret_cs | input | 16 | Returning CS selector |
| ret_ip | input | 64 | Return instruction pointer |
| cs_base | input | 32 | Base of the target code segment |
| long_mode | input | 1 | Processor is in long mode |
| cs_l | input | 1 | Target code segment is 64-bit |
| mode64 | input | 1 | Currently executing in 64-bit mode |
| to_user | input | 1 | Return goes to level 3 from a lower level |
| user_ssp | input | 64 | User-level shadow stack pointer |
| rd_req | output | 1 | Shadow stack read request |
| rd_addr | output | 64 | Read address |
| rd_valid | input | 1 | Read data valid, completes the request |
| rd_data | input | 64 | Read data |
| done | output | 1 | One-cycle completion pulse |
| fault_kind | output | 2 | 0 none, 1 control protection, 2 general protection |
| fault_code | output | 16 | Error code of the fault |
| new_ssp | output | 64 | Committed shadow stack pointer |

## Verification
The main path is tried with a 64-bit target, a compatibility target whose base addition wraps past 32 bits, and a legacy target that has the 64-bit code flag set but not long mode. Together these separate the two linear-address rules and confirm the truncation. Each compare is then broken on its own: CS, linear address, restored-pointer alignment and restored-pointer width. A further case breaks both CS and the width, which shows that the control-protection class wins over general protection. The user-level path, a misaligned incoming pointer, varied read latencies and a start pulse during a busy operation cover the no-read, hold and ignore behaviour.

// File: rtl/ssret_pkg.sv
package ssret_pkg;
  typedef enum logic [1:0] {
    FK_NONE = 2'd0,
    FK_CP   = 2'd1,
    FK_GP   = 2'd2
  } fault_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_POP  = 2'd1,
    ST_EVAL = 2'd2
  } ctl_state_e;
endpackage

// File: rtl/ssret_lin_addr.sv
module ssret_lin_addr #(
  parameter int DW = 64,
  parameter int BW = 32
) (
  input  logic [DW-1:0] ret_ip,
  input  logic [BW-1:0] cs_base,
  input  logic          long_mode,
  input  logic          cs_l,
  output logic [DW-1:0] lin_addr
);
  logic [BW-1:0] short_sum;

  always_comb begin
    short_sum = ret_ip[BW-1:0] + cs_base;
    if (long_mode && cs_l) lin_addr = ret_ip;
    else                   lin_addr = {{(DW-BW){1'b0}}, short_sum};
  end
endmodule

// File: rtl/ssret_pop_engine.sv
module ssret_pop_engine #(
  parameter int DW   = 64,
  parameter int NPOP = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DW-1:0]    base_ptr,
  input  logic             rd_valid,
  input  logic [DW-1:0]    rd_data,
  output logic             rd_req,
  output logic [DW-1:0]    rd_addr,
  output logic             pop_last,
  output logic [NPOP*DW-1:0] entries
);
  localparam int IW = (NPOP > 1) ? $clog2(NPOP) : 1;
  localparam logic [IW-1:0] LAST = IW'(NPOP - 1);
  localparam logic [DW-1:0] STEP = DW'(DW / 8);

  logic          active_q, active_d;
  logic [DW-1:0] ptr_q, ptr_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          take;

  assign take     = active_q && rd_valid;
  assign pop_last = take && (idx_q == LAST);
  assign rd_req   = active_q;
  assign rd_addr  = ptr_q;

  always_comb begin
    active_d = active_q;
    ptr_d    = ptr_q;
    idx_d    = idx_q;
    if (load) begin
      active_d = 1'b1;
      ptr_d    = base_ptr;
      idx_d    = '0;
    end else if (take) begin
      ptr_d = ptr_q + STEP;
      if (idx_q == LAST) begin
        active_d = 1'b0;
        idx_d    = '0;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      ptr_q    <= '0;
      idx_q    <= '0;
    end else begin
      active_q <= active_d;
      ptr_q    <= ptr_d;
      idx_q    <= idx_d;
    end
  end

  for (genvar g = 0; g < NPOP; g++) begin : g_entry
    logic [DW-1:0] ent_q;
    logic          ent_en;
    assign ent_en = take && (idx_q == IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_q <= '0;
      else if (ent_en) ent_q <= rd_data;
    end
    assign entries[g*DW +: DW] = ent_q;
  end
endmodule

// File: rtl/ssret_judge.sv
module ssret_judge
  import ssret_pkg::*;
#(
  parameter int DW      = 64,
  parameter int SELW    = 16,
  parameter int CW      = 16,
  parameter logic [CW-1:0] CP_CODE = 16'd3
) (
  input  logic [DW-1:0]   prev_ssp,
  input  logic [DW-1:0]   pop_lip,
  input  logic [DW-1:0]   pop_cs,
  input  logic [DW-1:0]   exp_lip,
  input  logic [SELW-1:0] exp_cs,
  input  logic            mode64,
  output fault_kind_e     kind,
  output logic [CW-1:0]   code
);
  localparam int HALF = DW / 2;

  logic cs_bad, lip_bad, align_bad, wide_bad;

  always_comb begin
    cs_bad    = pop_cs != {{(DW-SELW){1'b0}}, exp_cs};
    lip_bad   = pop_lip != exp_lip;
    align_bad = prev_ssp[1:0] != 2'b00;
    wide_bad  = !mode64 && (prev_ssp[DW-1:HALF] != '0);
    if (cs_bad || lip_bad || align_bad) begin
      kind = FK_CP;
      code = CP_CODE;
    end else if (wide_bad) begin
      kind = FK_GP;
      code = '0;
    end else begin
      kind = FK_NONE;
      code = '0;
    end
  end
endmodule

// File: rtl/ssret_verifier.sv
module ssret_verifier
  import ssret_pkg::*;
#(
  parameter int DW      = 64,
  parameter int SELW    = 16,
  parameter int BW      = 32,
  parameter int CW      = 16,
  parameter logic [CW-1:0] CP_CODE = 16'd3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [DW-1:0]   cur_ssp,
  input  logic [SELW-1:0] ret_cs,
  input  logic [DW-1:0]   ret_ip,
  input  logic [BW-1:0]   cs_base,
  input  logic            long_mode,
  input  logic            cs_l,
  input  logic            mode64,
  input  logic            to_user,
  input  logic [DW-1:0]   user_ssp,
  output logic            rd_req,
  output logic [DW-1:0]   rd_addr,
  input  logic            rd_valid,
  input  logic [DW-1:0]   rd_data,
  output logic            done,
  output logic [1:0]      fault_kind,
  output logic [CW-1:0]   fault_code,
  output logic [DW-1:0]   new_ssp
);
  localparam int NPOP = 3;
  localparam int ALIGN_BITS = 3;

  ctl_state_e    st_q, st_d;
  logic          done_q, done_d;
  fault_kind_e   kind_q, kind_d;
  logic [CW-1:0] code_q, code_d;
  logic [DW-1:0] ssp_q, ssp_d;

  logic            cap_en, pop_load, pop_last;
  logic [DW-1:0]   lip_calc, exp_lip_q;
  logic [SELW-1:0] exp_cs_q;
  logic            mode64_q;
  logic [NPOP*DW-1:0] entries;
  fault_kind_e     j_kind;
  logic [CW-1:0]   j_code;

  ssret_lin_addr #(.DW(DW), .BW(BW)) u_lin (
    .ret_ip(ret_ip), .cs_base(cs_base), .long_mode(long_mode),
    .cs_l(cs_l), .lin_addr(lip_calc)
  );

  ssret_pop_engine #(.DW(DW), .NPOP(NPOP)) u_pop (
    .clk(clk), .rst_n(rst_n), .load(pop_load), .base_ptr(cur_ssp),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_req(rd_req),
    .rd_addr(rd_addr), .pop_last(pop_last), .entries(entries)
  );

  ssret_judge #(.DW(DW), .SELW(SELW), .CW(CW), .CP_CODE(CP_CODE)) u_judge (
    .prev_ssp(entries[0*DW +: DW]), .pop_lip(entries[1*DW +: DW]),
    .pop_cs(entries[2*DW +: DW]), .exp_lip(exp_lip_q), .exp_cs(exp_cs_q),
    .mode64(mode64_q), .kind(j_kind), .code(j_code)
  );

  always_comb begin
    st_d     = st_q;
    done_d   = 1'b0;
    kind_d   = kind_q;
    code_d   = code_q;
    ssp_d    = ssp_q;
    cap_en   = 1'b0;
    pop_load = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          cap_en = 1'b1;
          if (cur_ssp[ALIGN_BITS-1:0] != '0) begin
            done_d = 1'b1;
            kind_d = FK_CP;
            code_d = CP_CODE;
          end else if (to_user) begin
            done_d = 1'b1;
            kind_d = FK_NONE;
            code_d = '0;
            ssp_d  = user_ssp;
          end else begin
            pop_load = 1'b1;
            st_d     = ST_POP;
          end
        end
      end
      ST_POP: begin
        if (pop_last) st_d = ST_EVAL;
      end
      ST_EVAL: begin
        done_d = 1'b1;
        kind_d = j_kind;
        code_d = j_code;
        if (j_kind == FK_NONE) ssp_d = entries[0*DW +: DW];
        st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
      kind_q <= FK_NONE;
      code_q <= '0;
      ssp_q  <= '0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      kind_q <= kind_d;
      code_q <= code_d;
      ssp_q  <= ssp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_lip_q <= '0;
      exp_cs_q  <= '0;
      mode64_q  <= 1'b0;
    end else if (cap_en) begin
      exp_lip_q <= lip_calc;
      exp_cs_q  <= ret_cs;
      mode64_q  <= mode64;
    end
  end

  assign done       = done_q;
  assign fault_kind = kind_q;
  assign fault_code = code_q;
  assign new_ssp    = ssp_q;
endmodule

// File: rtl/ssret_verifier_chk.sv
module ssret_verifier_chk #(
  parameter int DW = 64,
  parameter int CW = 16,
  parameter logic [CW-1:0] CP_CODE = 16'd3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_req,
  input logic [DW-1:0] rd_addr,
  input logic          rd_valid,
  input logic          done,
  input logic [1:0]    fault_kind,
  input logic [CW-1:0] fault_code,
  input logic [DW-1:0] new_ssp
);
  assert_rd_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (rd_addr[2:0] == 3'b000));

  assert_rd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));

  assert_rd_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_valid) |=> (!rd_req || (rd_addr == $past(rd_addr) + 64'd8)));

  assert_cp_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault_kind == 2'd1) |-> (fault_code == CP_CODE));

  assert_gp_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault_kind == 2'd2) |-> (fault_code == '0));

  assert_ok_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault_kind == 2'd0) |-> (fault_code == '0));

  assert_kind_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_kind != 2'd3);

  assert_fault_keeps_ssp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault_kind != 2'd0) |-> $stable(new_ssp));

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_no_read_at_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rd_req);
endmodule

bind ssret_verifier ssret_verifier_chk #(.DW(DW), .CW(CW), .CP_CODE(CP_CODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
  .rd_valid(rd_valid), .done(done), .fault_kind(fault_kind),
  .fault_code(fault_code), .new_ssp(new_ssp)
);

// File: tb/ssret_verifier_test.sv
`timescale 1ns/1ps
module ssret_verifier_test;
  logic        clk, rst_n, start;
  logic [63:0] cur_ssp, ret_ip, user_ssp, rd_addr, rd_data, new_ssp;
  logic [15:0] ret_cs, fault_code;
  logic [31:0] cs_base;
  logic        long_mode, cs_l, mode64, to_user;
  logic        rd_req, rd_valid, done;
  logic [1:0]  fault_kind;

  int n_chk = 0;
  int n_bad = 0;

  logic [63:0] mem_base;
  logic [63:0] mem_e [3];
  logic [63:0] addr_log [4];
  int resp_lat, wcnt, grants, req_cycles, done_cnt;

  ssret_verifier uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cur_ssp(cur_ssp),
    .ret_cs(ret_cs), .ret_ip(ret_ip), .cs_base(cs_base),
    .long_mode(long_mode), .cs_l(cs_l), .mode64(mode64),
    .to_user(to_user), .user_ssp(user_ssp), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .done(done), .fault_kind(fault_kind), .fault_code(fault_code),
    .new_ssp(new_ssp)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete (actual hung, expected finish)");
    summary();
    $finish;
  end

  // shadow stack memory model with programmable latency
  always @(negedge clk) begin
    if (rd_req) begin
      req_cycles++;
      if (rd_valid) begin
        rd_valid = 1'b0;
        wcnt = 0;
      end else if (wcnt >= resp_lat) begin
        logic [63:0] off;
        off = (rd_addr - mem_base) >> 3;
        rd_data = (off < 3) ? mem_e[off[1:0]] : 64'hDEAD_DEAD_DEAD_DEAD;
        if (grants < 4) addr_log[grants] = rd_addr;
        grants++;
        rd_valid = 1'b1;
      end else begin
        wcnt++;
      end
    end else begin
      rd_valid = 1'b0;
      wcnt = 0;
    end
    if (done) done_cnt++;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic setup(input logic [63:0] cur, input logic [15:0] cs,
                       input logic [63:0] ip, input logic [31:0] base,
                       input logic lm, input logic l, input logic m64,
                       input logic usr, input logic [63:0] uss);
    cur_ssp = cur; ret_cs = cs; ret_ip = ip; cs_base = base;
    long_mode = lm; cs_l = l; mode64 = m64; to_user = usr; user_ssp = uss;
    mem_base = cur;
  endtask

  task automatic go(input int lat);
    resp_lat = lat; grants = 0; req_cycles = 0; done_cnt = 0;
    for (int k = 0; k < 4; k++) addr_log[k] = '0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int k = 0; k < 100; k++) begin
      if (done) break;
      @(negedge clk);
    end
  endtask

  task automatic expect_result(input string tag, input logic [1:0] kind,
                               input logic [15:0] code, input logic [63:0] ssp);
    chk({tag, " done"}, {63'd0, done}, 64'd1);
    chk({tag, " kind"}, {62'd0, fault_kind}, {62'd0, kind});
    chk({tag, " code"}, {48'd0, fault_code}, {48'd0, code});
    chk({tag, " new_ssp"}, new_ssp, ssp);
    @(negedge clk);
    chk({tag, " pulse R12"}, {63'd0, done}, 64'd0);
  endtask

  task automatic t_reset();
    chk("R11 done", {63'd0, done}, 64'd0);
    chk("R11 rd_req", {63'd0, rd_req}, 64'd0);
    chk("R11 kind", {62'd0, fault_kind}, 64'd0);
    chk("R11 code", {48'd0, fault_code}, 64'd0);
    chk("R11 new_ssp", new_ssp, 64'd0);
  endtask

  task automatic t_ok64();
    setup(64'h1000, 16'h0033, 64'h0000_7fff_1234_5678, 32'h0, 1, 1, 1, 0, 0);
    mem_e[0] = 64'h0000_0001_0000_2000;
    mem_e[1] = 64'h0000_7fff_1234_5678;
    mem_e[2] = 64'h33;
    go(2);
    expect_result("R8 ok64", 2'd0, 16'd0, 64'h0000_0001_0000_2000);
    chk("R2 reads", grants, 3);
    chk("R2 addr0", addr_log[0], 64'h1000);
    chk("R2 addr1", addr_log[1], 64'h1008);
    chk("R2 addr2", addr_log[2], 64'h1010);
  endtask

  task automatic t_ok_compat();
    // base addition wraps past 32 bits: 0xFFFFFFF0 + 0x20 -> 0x10
    setup(64'h2000, 16'h0023, 64'h0000_0005_FFFF_FFF0, 32'h20, 1, 0, 0, 0, 0);
    mem_e[0] = 64'h3000; mem_e[1] = 64'h10; mem_e[2] = 64'h23;
    go(0);
    expect_result("R3 compat", 2'd0, 16'd0, 64'h3000);
  endtask

  task automatic t_ok_legacy();
    // 64-bit code flag without long mode still uses the 32-bit rule
    setup(64'h2800, 16'h0010, 64'h0000_0001_0000_0040, 32'h100, 0, 1, 0, 0, 0);
    mem_e[0] = 64'h3400; mem_e[1] = 64'h140; mem_e[2] = 64'h10;
    go(1);
    expect_result("R3 legacy", 2'd0, 16'd0, 64'h3400);
  endtask

  task automatic t_misaligned();
    setup(64'h1004, 16'h0033, 64'h40, 32'h0, 1, 1, 1, 0, 0);
    go(0);
    expect_result("R1 misaligned", 2'd1, 16'd3, 64'h3400);
    chk("R1 no read", req_cycles, 0);
  endtask

  task automatic t_cs_bad();
    setup(64'h1000, 16'h0033, 64'h40, 32'h0, 1, 1, 1, 0, 0);
    mem_e[0] = 64'h5000; mem_e[1] = 64'h40; mem_e[2] = 64'h1_0033;
    go(1);
    expect_result("R4 cs mismatch", 2'd1, 16'd3, 64'h3400);
    chk("R10 unchanged", new_ssp, 64'h3400);
  endtask

  task automatic t_lip_bad();
    setup(64'h1000, 16'h0033, 64'h40, 32'h0, 1, 1, 1, 0, 0);
    mem_e[0] = 64'h5000; mem_e[1] = 64'h48; mem_e[2] = 64'h33;
    go(0);
    expect_result("R5 lip mismatch", 2'd1, 16'd3, 64'h3400);
  endtask

  task automatic t_prev_align();
    setup(64'h1000, 16'h0033, 64'h40, 32'h0, 1, 1, 1, 0, 0);
    mem_e[0] = 64'h5002; mem_e[1] = 64'h40; mem_e[2] = 64'h33;
    go(0);
    expect_result("R6 prev align", 2'd1, 16'd3, 64'h3400);
    // 4-byte alignment is enough
    mem_e[0] = 64'h5004;
    go(0);
    expect_result("R6 prev 4-aligned ok", 2'd0, 16'd0, 64'h5004);
  endtask

  task automatic t_wide();
    setup(64'h1000, 16'h0023, 64'h40, 32'h0, 1, 0, 0, 0, 0);
    mem_e[0] = 64'h1_0000_3000; mem_e[1] = 64'h40; mem_e[2] = 64'h23;
    go(2);
    expect_result("R7 wide gp", 2'd2, 16'd0, 64'h5004);
    mem_e[2] = 64'h2b;
    go(0);
    expect_result("R7 cp precedence", 2'd1, 16'd3, 64'h5004);
  endtask

  task automatic t_user();
    setup(64'h1000, 16'h002b, 64'h40, 32'h0, 1, 1, 1, 1, 64'h7000_0008);
    go(0);
    expect_result("R9 user", 2'd0, 16'd0, 64'h7000_0008);
    chk("R9 no read", req_cycles, 0);
    setup(64'h1001, 16'h002b, 64'h40, 32'h0, 1, 1, 1, 1, 64'h9000);
    go(0);
    expect_result("R1 user misaligned", 2'd1, 16'd3, 64'h7000_0008);
  endtask

  task automatic t_busy();
    setup(64'h1000, 16'h0033, 64'h40, 32'h0, 1, 1, 1, 0, 0);
    mem_e[0] = 64'h6000; mem_e[1] = 64'h40; mem_e[2] = 64'h33;
    resp_lat = 3; grants = 0; req_cycles = 0; done_cnt = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    to_user = 1'b1; user_ssp = 64'hAAAA_0000; cur_ssp = 64'h1003;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int k = 0; k < 100; k++) begin
      if (done) break;
      @(negedge clk);
    end
    expect_result("R12 busy ignore", 2'd0, 16'd0, 64'h6000);
    chk("R12 busy reads", grants, 3);
    repeat (10) @(negedge clk);
    chk("R12 single done", done_cnt, 1);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; rd_valid = 1'b0; rd_data = '0;
    resp_lat = 0; wcnt = 0; grants = 0; req_cycles = 0; done_cnt = 0;
    setup(0, 0, 0, 0, 0, 0, 0, 0, 0);
    for (int k = 0; k < 3; k++) mem_e[k] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_ok64();
    t_ok_compat();
    t_ok_legacy();
    t_misaligned();
    t_cs_bad();
    t_lip_bad();
    t_prev_align();
    t_wide();
    t_user();
    t_busy();
    summary();
    $finish;
  end
endmodule